// File: doc/BRIEF.md
# Sample Memory Block-Move Engine

This engine copies a block of bytes between a host-side byte stream and a local sample memory. Software loads a 16-bit paragraph position and a 4-bit fine offset, writes a control byte, and then a start pulse arrives with a unit count and a terminal-count flag. The engine works out the local start address, moves one byte per clock whenever both sides are ready, and raises a transfer request and an optional interrupt when the block ends on terminal count.

The position registers are advanced as soon as a transfer is launched, so software reading them sees where the next block will land. Uploads from the host can flip the sign bit of each sample on the way in, which converts unsigned data to two's complement. A 16-bit channel folds the address so that every unit occupies two bytes.

The controller is a three-state machine. `ST_IDLE` waits for a start pulse. On the launch transition it moves to `ST_MOVE` when the byte total is nonzero and straight to `ST_FINISH` when it is zero. `ST_MOVE` loops while bytes remain and takes the last-beat transition to `ST_FINISH`. `ST_FINISH` applies the terminal-count effects and always returns to `ST_IDLE`.

Top module: `smem_dma`

## Requirements
- R1: In 8-bit channel mode (`wide`=0) the first local byte address is the position register times 16 plus the fine offset.
- R2: In 16-bit channel mode (`wide`=1) that raw address keeps bits 19:18, its bits 16:4 are doubled into bits 17:5, and bits 4:0 become zero.
- R3: Control bit 1 picks the direction: 0 writes stream bytes to local memory (`mem_we`), 1 reads local memory onto the output stream (`mem_re`); the two strobes are never high together.
- R4: With control bit 7 set and direction 0, bit 7 of each copied byte is inverted; with direction 1 bytes pass unchanged.
- R5: With control bit 6 set, the first byte of every unit is copied without inversion; in 16-bit mode the second byte of each unit still follows R4.
- R6: On an accepted start with count N, the position register becomes position + N/16 and the fine offset becomes the low 4 bits of N + fine, visible in the cycle after the start.
- R7: A transfer moves N bytes (2N in 16-bit mode), one per clock while the stream side and `mem_ready` are both ready, at consecutive addresses.
- R8: A start pulse while a transfer is in progress is ignored: position, fine offset and byte total are unchanged.
- R9: One cycle after the last byte, if the terminal-count flag was given with the start, control bit 0 clears; if control bit 5 is also set, `irq` rises. Without the flag neither changes.
- R10: `ctrl_rdata` is the stored control byte with bit 2 forced to `wide` and bit 6 forced high when an interrupt is pending; a read strobe clears the pending interrupt and stored bits 2 and 6.
- R11: Writing the control byte with bit 0 set drives `dreq` high, and it stays high until terminal count or another control write.
- R12: After reset `dreq`, `irq`, both memory strobes, the position, the fine offset and `ctrl_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctrl_wr | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte write value |
| ctrl_rd | input | 1 | Control byte read strobe (clears pending interrupt) |
| ctrl_rdata | output | 8 | Control byte read value |
| pos_wr | input | 1 | Position register write strobe |
| pos_wdata | input | 16 | Position register write value |
| fine_wr | input | 1 | Fine offset write strobe |
| fine_wdata | input | 4 | Fine offset write value |
| wide | input | 1 | 16-bit channel in use |
| start | input | 1 | Transfer launch pulse |
| xfer_count | input | 16 | Unit count for the launch |
| tc | input | 1 | Launch ends on terminal count |
| in_valid | input | 1 | Host stream byte valid |
| in_data | input | 8 | Host stream byte |
| in_ready | output | 1 | Host stream byte accepted |
| out_valid | output | 1 | Outgoing stream byte valid |
| out_data | output | 8 | Outgoing stream byte |
| out_ready | input | 1 | Outgoing stream sink ready |
| mem_we | output | 1 | Local memory write strobe |
| mem_re | output | 1 | Local memory read strobe |
| mem_addr | output | 20 | Local memory byte address |
| mem_wdata | output | 8 | Local memory write byte |
| mem_rdata | input | 8 | Local memory read byte (same cycle) |
| mem_ready | input | 1 | Local memory accepts the access |
| pos_q | output | 16 | Current position register |
| fine_q | output | 4 | Current fine offset |
| dreq | output | 1 | Transfer request toward the host |
| irq | output | 1 | Terminal-count interrupt pending |

## Verification
A wrong latched address or byte counter shows at the memory port on the very first beat, as an off address, or at the end as a short or long block with bytes outside the expected window. A wrongly latched mode bit corrupts bit 7 of the stored samples, visible on the first byte of the affected parity. Faulty terminal-count handling appears one cycle after the last beat on `dreq` and `irq`, and a stuck pending flag appears on `ctrl_rdata` in the cycle after a read strobe.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MOVE,
        ST_FINISH
    } dma_state_e;

    localparam int BYTE_W      = 8;
    localparam int CTL_REQ     = 0;
    localparam int CTL_DIR     = 1;
    localparam int CTL_WIDE_RD = 2;
    localparam int CTL_TCIRQ   = 5;
    localparam int CTL_LOWRAW  = 6;
    localparam int CTL_INV     = 7;

endpackage

// File: rtl/dma_addr_xlat.sv
module dma_addr_xlat #(
    parameter int POS_W  = 16,
    parameter int FINE_W = 4,
    localparam int ADDR_W = POS_W + FINE_W
) (
    input  logic [POS_W-1:0]  pos,
    input  logic [FINE_W-1:0] fine,
    input  logic              wide,
    output logic [ADDR_W-1:0] addr
);
    localparam int MID_W = ADDR_W - 3 - FINE_W;
    localparam logic [ADDR_W-1:0] HI_MASK  = {2'b11, {(ADDR_W-2){1'b0}}};
    localparam logic [ADDR_W-1:0] MID_MASK = {3'b000, {MID_W{1'b1}}, {FINE_W{1'b0}}};

    logic [ADDR_W-1:0] raw;

    always_comb begin
        raw = {pos, {FINE_W{1'b0}}} + {{POS_W{1'b0}}, fine};
        if (wide) begin
            addr = (raw & HI_MASK) | ((raw & MID_MASK) << 1);
        end else begin
            addr = raw;
        end
    end
endmodule

// File: rtl/dma_byte_xform.sv
module dma_byte_xform
    import dma_pkg::*;
(
    input  logic [BYTE_W-1:0] din,
    input  logic              inv_en,
    input  logic              raw_en,
    input  logic              first,
    output logic [BYTE_W-1:0] dout
);
    logic flip;

    always_comb begin
        flip = inv_en && !(raw_en && first);
        dout = din ^ {flip, {(BYTE_W-1){1'b0}}};
    end
endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
    import dma_pkg::*;
#(
    parameter int POS_W  = 16,
    parameter int FINE_W = 4,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [BYTE_W-1:0] ctrl_wdata,
    input  logic              ctrl_rd,
    input  logic              pos_wr,
    input  logic [POS_W-1:0]  pos_wdata,
    input  logic              fine_wr,
    input  logic [FINE_W-1:0] fine_wdata,
    input  logic              wide,
    input  logic              launch,
    input  logic [CNT_W-1:0]  launch_cnt,
    input  logic              tc_event,
    output logic              req_bit,
    output logic              dir_bit,
    output logic              lowraw_bit,
    output logic              inv_bit,
    output logic [POS_W-1:0]  pos_q,
    output logic [FINE_W-1:0] fine_q,
    output logic              pend_q,
    output logic [BYTE_W-1:0] rd_value
);
    localparam logic [BYTE_W-1:0] RD_CLR =
        ~((BYTE_W'(1) << CTL_WIDE_RD) | (BYTE_W'(1) << CTL_LOWRAW));

    logic [BYTE_W-1:0] ctrl_q, ctrl_d;
    logic [POS_W-1:0]  pos_d, pos_inc;
    logic [FINE_W-1:0] fine_d;
    logic              pend_d;

    assign pos_inc = POS_W'(launch_cnt >> FINE_W);

    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_rd)  ctrl_d = ctrl_d & RD_CLR;
        if (tc_event) ctrl_d[CTL_REQ] = 1'b0;
        if (ctrl_wr)  ctrl_d = ctrl_wdata;

        pend_d = pend_q;
        if (ctrl_rd) pend_d = 1'b0;
        if (tc_event && ctrl_q[CTL_TCIRQ]) pend_d = 1'b1;

        pos_d  = pos_q;
        fine_d = fine_q;
        if (pos_wr)  pos_d  = pos_wdata;
        if (fine_wr) fine_d = fine_wdata;
        if (launch) begin
            pos_d  = pos_q + pos_inc;
            fine_d = fine_q + launch_cnt[FINE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            pend_q <= 1'b0;
            pos_q  <= '0;
            fine_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            pend_q <= pend_d;
            pos_q  <= pos_d;
            fine_q <= fine_d;
        end
    end

    always_comb begin
        rd_value              = ctrl_q;
        rd_value[CTL_WIDE_RD] = ctrl_q[CTL_WIDE_RD] | wide;
        rd_value[CTL_LOWRAW]  = ctrl_q[CTL_LOWRAW] | pend_q;
    end

    assign req_bit    = ctrl_q[CTL_REQ];
    assign dir_bit    = ctrl_q[CTL_DIR];
    assign lowraw_bit = ctrl_q[CTL_LOWRAW];
    assign inv_bit    = ctrl_q[CTL_INV];
endmodule

// File: rtl/smem_dma.sv
module smem_dma
    import dma_pkg::*;
#(
    parameter int POS_W  = 16,
    parameter int FINE_W = 4,
    parameter int CNT_W  = 16,
    localparam int ADDR_W = POS_W + FINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [7:0]        ctrl_wdata,
    input  logic              ctrl_rd,
    output logic [7:0]        ctrl_rdata,
    input  logic              pos_wr,
    input  logic [POS_W-1:0]  pos_wdata,
    input  logic              fine_wr,
    input  logic [FINE_W-1:0] fine_wdata,
    input  logic              wide,
    input  logic              start,
    input  logic [CNT_W-1:0]  xfer_count,
    input  logic              tc,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [7:0]        out_data,
    input  logic              out_ready,
    output logic              mem_we,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ready,
    output logic [POS_W-1:0]  pos_q,
    output logic [FINE_W-1:0] fine_q,
    output logic              dreq,
    output logic              irq
);
    localparam int BYTES_W = CNT_W + 1;

    dma_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q, start_addr;
    logic [BYTES_W-1:0] rem_q, bytes_total;
    logic              hi_q, tc_q, dir_q, inv_q, raw_q, wide_q;
    logic              launch, beat, tc_event;
    logic              req_bit, dir_bit, lowraw_bit, inv_bit, pend_q;
    logic [7:0]        xf_in, xf_out;

    assign launch      = (state_q == ST_IDLE) && start;
    assign tc_event    = (state_q == ST_FINISH) && tc_q;
    assign bytes_total = wide ? {xfer_count, 1'b0} : {1'b0, xfer_count};

    dma_ctrl_regs #(
        .POS_W (POS_W),
        .FINE_W(FINE_W),
        .CNT_W (CNT_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .ctrl_wdata(ctrl_wdata),
        .ctrl_rd   (ctrl_rd),
        .pos_wr    (pos_wr),
        .pos_wdata (pos_wdata),
        .fine_wr   (fine_wr),
        .fine_wdata(fine_wdata),
        .wide      (wide),
        .launch    (launch),
        .launch_cnt(xfer_count),
        .tc_event  (tc_event),
        .req_bit   (req_bit),
        .dir_bit   (dir_bit),
        .lowraw_bit(lowraw_bit),
        .inv_bit   (inv_bit),
        .pos_q     (pos_q),
        .fine_q    (fine_q),
        .pend_q    (pend_q),
        .rd_value  (ctrl_rdata)
    );

    dma_addr_xlat #(
        .POS_W (POS_W),
        .FINE_W(FINE_W)
    ) u_xlat (
        .pos (pos_q),
        .fine(fine_q),
        .wide(wide),
        .addr(start_addr)
    );

    assign xf_in = dir_q ? mem_rdata : in_data;

    dma_byte_xform u_xform (
        .din   (xf_in),
        .inv_en(inv_q && !dir_q),
        .raw_en(raw_q),
        .first (!hi_q),
        .dout  (xf_out)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (launch) state_d = (bytes_total == '0) ? ST_FINISH : ST_MOVE;
            end
            ST_MOVE: begin
                if (beat && rem_q == BYTES_W'(1)) state_d = ST_FINISH;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        beat      = 1'b0;
        unique case (state_q)
            ST_MOVE: begin
                if (dir_q) begin
                    mem_re    = out_ready;
                    out_valid = mem_ready;
                    beat      = out_ready && mem_ready;
                end else begin
                    mem_we    = in_valid;
                    in_ready  = mem_ready;
                    beat      = in_valid && mem_ready;
                end
            end
            default: ;
        endcase
    end

    // transfer datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            rem_q  <= '0;
            hi_q   <= 1'b0;
            tc_q   <= 1'b0;
            dir_q  <= 1'b0;
            inv_q  <= 1'b0;
            raw_q  <= 1'b0;
            wide_q <= 1'b0;
        end else if (launch) begin
            addr_q <= start_addr;
            rem_q  <= bytes_total;
            hi_q   <= 1'b0;
            tc_q   <= tc;
            dir_q  <= dir_bit;
            inv_q  <= inv_bit;
            raw_q  <= lowraw_bit;
            wide_q <= wide;
        end else if (beat) begin
            addr_q <= addr_q + ADDR_W'(1);
            rem_q  <= rem_q - BYTES_W'(1);
            hi_q   <= wide_q && !hi_q;
        end
    end

    assign mem_addr  = addr_q;
    assign mem_wdata = xf_out;
    assign out_data  = xf_out;
    assign dreq      = req_bit;
    assign irq       = pend_q;
endmodule

// File: rtl/dma_checker.sv
module dma_checker
    import dma_pkg::*;
#(
    parameter int POS_W  = 16,
    parameter int FINE_W = 4,
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input dma_state_e        state_q,
    input logic              tc_q,
    input logic              mem_we,
    input logic              mem_re,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              start,
    input logic              pos_wr,
    input logic              fine_wr,
    input logic [POS_W-1:0]  pos_q,
    input logic [FINE_W-1:0] fine_q,
    input logic              ctrl_wr,
    input logic              ctrl_rd,
    input logic              dreq,
    input logic              irq
);
    logic fin_tc;
    logic mv_beat;
    assign fin_tc  = (state_q == ST_FINISH) && tc_q;
    assign mv_beat = (mem_we || mem_re) && mem_ready;

    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mv_beat |=> (state_q != ST_MOVE) || (mem_addr == ADDR_W'($past(mem_addr) + ADDR_W'(1))));

    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && start && !pos_wr && !fine_wr) |=> ($stable(pos_q) && $stable(fine_q)));

    assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(fin_tc));

    assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd && !fin_tc) |=> !irq);

    assert_dreq_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (dreq && !ctrl_wr && !fin_tc) |=> dreq);

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_MOVE) |-> !(mem_we || mem_re));
endmodule

bind smem_dma dma_checker #(
    .POS_W (POS_W),
    .FINE_W(FINE_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state_q  (state_q),
    .tc_q     (tc_q),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .mem_ready(mem_ready),
    .mem_addr (mem_addr),
    .start    (start),
    .pos_wr   (pos_wr),
    .fine_wr  (fine_wr),
    .pos_q    (pos_q),
    .fine_q   (fine_q),
    .ctrl_wr  (ctrl_wr),
    .ctrl_rd  (ctrl_rd),
    .dreq     (dreq),
    .irq      (irq)
);

// File: tb/smem_dma_tb.sv
module smem_dma_tb;

    typedef struct packed {
        logic [7:0]  ctrl;
        logic [15:0] pos;
        logic [3:0]  fine;
        logic        wide;
        logic [15:0] cnt;
        logic        tc;
        logic        stall;
        logic        restart;
        logic [19:0] exp_addr;
        logic [15:0] exp_pos;
        logic [3:0]  exp_fine;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [0:NVEC-1] = '{
        '{8'h21, 16'h0010, 4'h3, 1'b0, 16'd5,  1'b1, 1'b0, 1'b0, 20'h00103, 16'h0010, 4'h8},
        '{8'h81, 16'h0020, 4'h0, 1'b0, 16'd20, 1'b0, 1'b0, 1'b1, 20'h00200, 16'h0021, 4'h4},
        '{8'hC1, 16'h0030, 4'hF, 1'b0, 16'd4,  1'b1, 1'b0, 1'b0, 20'h0030F, 16'h0030, 4'h3},
        '{8'h81, 16'h0048, 4'h2, 1'b1, 16'd3,  1'b1, 1'b0, 1'b0, 20'h00900, 16'h0048, 4'h5},
        '{8'hE1, 16'h0050, 4'h0, 1'b1, 16'd2,  1'b1, 1'b0, 1'b0, 20'h00A00, 16'h0050, 4'h2},
        '{8'h83, 16'h0060, 4'h1, 1'b0, 16'd6,  1'b1, 1'b0, 1'b0, 20'h00601, 16'h0060, 4'h7},
        '{8'h01, 16'h0070, 4'h0, 1'b0, 16'd17, 1'b1, 1'b1, 1'b0, 20'h00700, 16'h0071, 4'h1},
        '{8'h23, 16'h0080, 4'h0, 1'b1, 16'd2,  1'b1, 1'b0, 1'b0, 20'h01000, 16'h0080, 4'h2},
        '{8'h21, 16'h0090, 4'h5, 1'b0, 16'd0,  1'b1, 1'b0, 1'b0, 20'h00000, 16'h0090, 4'h5}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr = 1'b0, ctrl_rd = 1'b0, pos_wr = 1'b0, fine_wr = 1'b0;
    logic [7:0]  ctrl_wdata = '0;
    logic [7:0]  ctrl_rdata;
    logic [15:0] pos_wdata = '0;
    logic [3:0]  fine_wdata = '0;
    logic        wide = 1'b0, start = 1'b0, tc = 1'b0;
    logic [15:0] xfer_count = '0;
    logic        in_valid = 1'b1;
    logic [7:0]  in_data;
    logic        in_ready, out_valid, out_ready;
    logic [7:0]  out_data;
    logic        mem_we, mem_re, mem_ready;
    logic [19:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic [15:0] pos_q;
    logic [3:0]  fine_q;
    logic        dreq, irq;

    logic [7:0]  mem [0:8191];
    logic [7:0]  cap [0:63];
    logic        fill = 1'b0, clr = 1'b0, stall_en = 1'b0, seen;
    logic [19:0] first_addr;
    int          acc_cnt, out_cnt, cur_v;
    int          n_chk = 0, n_fail = 0;

    assign out_ready = 1'b1;

    always #5 clk = ~clk;

    function automatic logic [7:0] init_byte(input int a);
        return 8'(a * 7 + 3);
    endfunction

    function automatic logic [7:0] src_byte(input int v, input int k);
        return 8'(v * 8'h31 + 8'h5A + k * 13);
    endfunction

    assign in_data   = src_byte(cur_v, acc_cnt);
    assign mem_rdata = mem[mem_addr[12:0]];

    smem_dma u_dut (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_rd(ctrl_rd), .ctrl_rdata(ctrl_rdata),
        .pos_wr(pos_wr), .pos_wdata(pos_wdata), .fine_wr(fine_wr), .fine_wdata(fine_wdata),
        .wide(wide), .start(start), .xfer_count(xfer_count), .tc(tc),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .pos_q(pos_q), .fine_q(fine_q), .dreq(dreq), .irq(irq)
    );

    // memory model and stream monitors
    always @(posedge clk) begin
        if (fill) begin
            for (int i = 0; i < 8192; i++) mem[i] <= init_byte(i);
        end else if (mem_we && mem_ready) begin
            mem[mem_addr[12:0]] <= mem_wdata;
        end
        if (clr) begin
            acc_cnt <= 0;
            out_cnt <= 0;
            seen    <= 1'b0;
        end else begin
            if (in_valid && in_ready) acc_cnt <= acc_cnt + 1;
            if (out_valid && out_ready) begin
                cap[out_cnt[5:0]] <= out_data;
                out_cnt <= out_cnt + 1;
            end
            if ((mem_we || mem_re) && mem_ready && !seen) begin
                first_addr <= mem_addr;
                seen       <= 1'b1;
            end
        end
    end

    always @(negedge clk) begin
        if (stall_en) mem_ready <= ~mem_ready;
        else          mem_ready <= 1'b1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_vec(input int v);
        vec_t t;
        int   nb;
        logic [7:0] stored, e, got;
        logic pend;
        t  = VECS[v];
        nb = t.wide ? 2 * int'(t.cnt) : int'(t.cnt);
        @(negedge clk);
        cur_v = v;
        clr = 1'b1;
        ctrl_wr = 1'b1; ctrl_wdata = t.ctrl;
        pos_wr = 1'b1;  pos_wdata = t.pos;
        fine_wr = 1'b1; fine_wdata = t.fine;
        wide = t.wide;  stall_en = t.stall;
        @(negedge clk);
        clr = 1'b0;
        ctrl_wr = 1'b0; pos_wr = 1'b0; fine_wr = 1'b0;
        chk("R11 dreq after control write", 32'(dreq), 32'(1));
        start = 1'b1; xfer_count = t.cnt; tc = t.tc;
        @(negedge clk);
        start = 1'b0;
        chk("R6 position after start", 32'(pos_q), 32'(t.exp_pos));
        chk("R6 fine offset after start", 32'(fine_q), 32'(t.exp_fine));
        if (t.restart) begin
            start = 1'b1; xfer_count = 16'd9; tc = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk("R8 position unchanged by second start", 32'(pos_q), 32'(t.exp_pos));
            chk("R8 fine unchanged by second start", 32'(fine_q), 32'(t.exp_fine));
            repeat (nb - 1) @(negedge clk);
        end else if (!t.stall) begin
            repeat (nb) @(negedge clk);
        end else begin
            repeat (2 * nb + 2) @(negedge clk);
        end
        if (!t.stall && nb > 0)
            chk("R7 one byte per clock", 32'(t.ctrl[1] ? out_cnt : acc_cnt), 32'(nb));
        repeat (3) @(negedge clk);
        chk("R7 byte total", 32'(t.ctrl[1] ? out_cnt : acc_cnt), 32'(nb));
        if (nb > 0)
            chk(t.wide ? "R2 folded start address" : "R1 start address",
                32'(first_addr), 32'(t.exp_addr));
        for (int k = 0; k < nb; k++) begin
            if (t.ctrl[1]) begin
                e   = init_byte(int'(t.exp_addr) + k);
                got = cap[k];
                chk("R4 R3 read direction passes bytes unchanged", 32'(got), 32'(e));
            end else begin
                e = src_byte(v, k);
                if (t.ctrl[7] && !(t.ctrl[6] && (!t.wide || (k % 2 == 0)))) e = e ^ 8'h80;
                got = mem[13'(int'(t.exp_addr) + k)];
                chk(t.ctrl[6] ? "R5 low byte raw copy" : "R4 sign inversion on upload",
                    32'(got), 32'(e));
            end
        end
        stored = t.tc ? (t.ctrl & 8'hFE) : t.ctrl;
        pend   = t.tc && t.ctrl[5];
        chk("R9 request after end", 32'(dreq), 32'(!t.tc));
        chk("R9 interrupt after end", 32'(irq), 32'(pend));
        e = stored | {1'b0, pend, 3'b000, t.wide, 2'b00};
        chk("R10 control read value", 32'(ctrl_rdata), 32'(e));
        ctrl_rd = 1'b1;
        @(negedge clk);
        ctrl_rd = 1'b0;
        chk("R10 interrupt cleared by read", 32'(irq), 32'(0));
        e = (stored & 8'hBB) | {5'b00000, t.wide, 2'b00};
        chk("R10 stored bits cleared by read", 32'(ctrl_rdata), 32'(e));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        cur_v = 0;
        mem_ready = 1'b1;
        fill = 1'b1;
        clr  = 1'b1;
        repeat (3) @(negedge clk);
        fill = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 dreq after reset", 32'(dreq), 32'(0));
        chk("R12 irq after reset", 32'(irq), 32'(0));
        chk("R12 strobes after reset", 32'({mem_we, mem_re}), 32'(0));
        chk("R12 position after reset", 32'(pos_q), 32'(0));
        chk("R12 fine after reset", 32'(fine_q), 32'(0));
        chk("R12 control read after reset", 32'(ctrl_rdata), 32'(0));
        for (int v = 0; v < NVEC; v++) run_vec(v);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule